// File: doc/BRIEF.md
# Channel Number to Carrier Frequency Converter

This block turns a 16-bit radio channel number into the carrier frequency of that channel, in units of 100 kHz. It also returns an 8-bit one-hot code for the frequency band the channel belongs to. A direction select picks the value it returns. The transmit (uplink) frequency is a per-band base plus 200 kHz per channel step. The receive (downlink) frequency adds a per-band duplex spacing to that. Bit 15 of the channel word marks a channel of the 1900 band. The remaining low twelve bits are decoded against eight numeric ranges, which are tested in a fixed priority.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream. A single register stage sits between the two. The input stream accepts a word when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. A result held with `out_ready` low stays unchanged until the consumer takes it. This lets a scheduler queue channel requests at full rate and also lets it stall them.

Top module: `chan_freq_conv`

## Requirements
- R1: Bits 14..12 of `in_chan` have no effect on the result. Only bit 15 (1900 flag) and bits 11..0 (channel index) are used.
- R2: When bit 15 is set, the channel is in the 1900 band regardless of the index. Band code is 0x08. Uplink is 18502 + 2*(index-512) taken modulo 2^16, and downlink adds 800.
- R3: Without the flag, the index is tested in this priority order. Band codes are 0x01 for 850, 0x02 for 900, 0x04 for 1800, 0x10 for 450, 0x20 for 480, 0x40 for 750 and 0x80 for 810. The ranges are:
  - 0..124: 900
  - 955..1023: 900
  - 128..251: 850
  - 512..885: 1800
  - 259..293: 450
  - 306..340: 480
  - 350..425: 810
  - 438..511: 750
- R4: The uplink frequency is base + 2*(index - first), with (base, first) as follows: 900 (8900, 0), 850 (8242, 128), 1800 (17102, 512), 450 (4506, 259), 480 (4790, 306), 810 (8060, 350) and 750 (7472, 438).
- R5: Indices 955..1023 give 8900 - 2*(1024 - index), computed in 16-bit wrapping arithmetic (955 -> 8762, 1023 -> 8898).
- R6: With `in_uplink` low, the output is the uplink value plus the duplex spacing. The spacing is 450 for 900, extended 900, 850 and 810. It is 950 for 1800, 100 for 450 and 480, and 300 for 750.
- R7: An index that matches no range gives band code 0x04 and frequency 0xFFFF in both directions.
- R8: A word accepted on a clock edge appears on `out_valid`, `out_freq` and `out_band` right after that same edge.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the outputs are held unchanged. When the consumer takes the result, a new word may be accepted in the same cycle.
- R10: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request word present |
| in_ready | output | 1 | Request word can be taken this cycle |
| in_chan | input | 16 | Channel number, bit 15 = 1900 flag |
| in_uplink | input | 1 | 1 = return uplink frequency, 0 = downlink |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_freq | output | 16 | Carrier frequency in 100 kHz units, 0xFFFF if unmatched |
| out_band | output | 8 | One-hot band code |

## Verification
The hardest situation to reach from the ports is a stalled result with a new request waiting. The bench raises the request, releases `out_ready`, and needs the held word to leave and the new one to land on the same edge. It reaches this by keeping `out_ready` low across several cycles while the next word is driven. It then raises `out_ready` without dropping `in_valid`, and checks the held value at every stalled cycle and the new value after the handover. The gaps between ranges (125, 252, 300, 4095) and the flag set over a small index are driven to reach the unmatched and wrapping corners.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  localparam int CHAN_W   = 16;
  localparam int FREQ_W   = 16;
  localparam int IDX_W    = 12;
  localparam int BAND_W   = 8;
  localparam int FLAG_BIT = 15;
  localparam int NUM_SPAN = 8;

  // Numeric spans occupy enum values 1..NUM_SPAN in priority order.
  typedef enum logic [3:0] {
    RG_PCS  = 4'd0,
    RG_P900 = 4'd1,
    RG_E900 = 4'd2,
    RG_850  = 4'd3,
    RG_1800 = 4'd4,
    RG_450  = 4'd5,
    RG_480  = 4'd6,
    RG_810  = 4'd7,
    RG_750  = 4'd8,
    RG_NONE = 4'd9
  } range_e;

  function automatic logic [IDX_W-1:0] span_lo(range_e r);
    case (r)
      RG_P900: return IDX_W'(0);
      RG_E900: return IDX_W'(955);
      RG_850:  return IDX_W'(128);
      RG_1800: return IDX_W'(512);
      RG_450:  return IDX_W'(259);
      RG_480:  return IDX_W'(306);
      RG_810:  return IDX_W'(350);
      RG_750:  return IDX_W'(438);
      default: return '1;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] span_hi(range_e r);
    case (r)
      RG_P900: return IDX_W'(124);
      RG_E900: return IDX_W'(1023);
      RG_850:  return IDX_W'(251);
      RG_1800: return IDX_W'(885);
      RG_450:  return IDX_W'(293);
      RG_480:  return IDX_W'(340);
      RG_810:  return IDX_W'(425);
      RG_750:  return IDX_W'(511);
      default: return '0;
    endcase
  endfunction

  function automatic logic [FREQ_W-1:0] ul_base(range_e r);
    case (r)
      RG_PCS:  return FREQ_W'(18502);
      RG_P900: return FREQ_W'(8900);
      RG_E900: return FREQ_W'(8900);
      RG_850:  return FREQ_W'(8242);
      RG_1800: return FREQ_W'(17102);
      RG_450:  return FREQ_W'(4506);
      RG_480:  return FREQ_W'(4790);
      RG_810:  return FREQ_W'(8060);
      RG_750:  return FREQ_W'(7472);
      default: return '0;
    endcase
  endfunction

  function automatic logic [FREQ_W-1:0] first_ch(range_e r);
    case (r)
      RG_PCS:  return FREQ_W'(512);
      RG_E900: return FREQ_W'(1024);
      RG_850:  return FREQ_W'(128);
      RG_1800: return FREQ_W'(512);
      RG_450:  return FREQ_W'(259);
      RG_480:  return FREQ_W'(306);
      RG_810:  return FREQ_W'(350);
      RG_750:  return FREQ_W'(438);
      default: return '0;
    endcase
  endfunction

  function automatic logic [FREQ_W-1:0] duplex(range_e r);
    case (r)
      RG_PCS:  return FREQ_W'(800);
      RG_P900, RG_E900, RG_850, RG_810: return FREQ_W'(450);
      RG_1800: return FREQ_W'(950);
      RG_450, RG_480: return FREQ_W'(100);
      RG_750:  return FREQ_W'(300);
      default: return '0;
    endcase
  endfunction

  function automatic logic [BAND_W-1:0] band_code(range_e r);
    case (r)
      RG_850:  return BAND_W'(8'h01);
      RG_P900, RG_E900: return BAND_W'(8'h02);
      RG_1800: return BAND_W'(8'h04);
      RG_PCS:  return BAND_W'(8'h08);
      RG_450:  return BAND_W'(8'h10);
      RG_480:  return BAND_W'(8'h20);
      RG_750:  return BAND_W'(8'h40);
      RG_810:  return BAND_W'(8'h80);
      default: return BAND_W'(8'h04);
    endcase
  endfunction
endpackage

// File: rtl/cfc_range_sel.sv
module cfc_range_sel
  import cfc_pkg::*;
(
  input  logic [CHAN_W-1:0] chan,
  output range_e            rg,
  output logic [IDX_W-1:0]  idx
);
  logic              pcs_flag;
  logic [NUM_SPAN:1] hit;

  assign pcs_flag = chan[FLAG_BIT];
  assign idx      = chan[IDX_W-1:0];

  for (genvar g = 1; g <= NUM_SPAN; g++) begin : g_span
    localparam range_e RG = range_e'(4'(g));
    assign hit[g] = (idx >= span_lo(RG)) && (idx <= span_hi(RG));
  end

  always_comb begin
    rg = RG_NONE;
    for (int k = NUM_SPAN; k >= 1; k--) begin
      if (hit[k]) rg = range_e'(4'(k));
    end
    if (pcs_flag) rg = RG_PCS;
  end
endmodule

// File: rtl/cfc_freq_calc.sv
module cfc_freq_calc
  import cfc_pkg::*;
(
  input  range_e            rg,
  input  logic [IDX_W-1:0]  idx,
  input  logic              uplink,
  output logic [FREQ_W-1:0] freq
);
  logic [FREQ_W-1:0] step;
  logic [FREQ_W-1:0] ul_f;
  logic [FREQ_W-1:0] dl_f;

  always_comb begin
    step = FREQ_W'(idx) - first_ch(rg);
    ul_f = ul_base(rg) + (step << 1);
    dl_f = ul_f + duplex(rg);
    if (rg == RG_NONE) freq = '1;
    else               freq = uplink ? ul_f : dl_f;
  end
endmodule

// File: rtl/cfc_band_map.sv
module cfc_band_map
  import cfc_pkg::*;
(
  input  range_e            rg,
  output logic [BAND_W-1:0] band
);
  assign band = band_code(rg);
endmodule

// File: rtl/chan_freq_conv.sv
module chan_freq_conv
  import cfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAN_W-1:0] in_chan,
  input  logic              in_uplink,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FREQ_W-1:0] out_freq,
  output logic [BAND_W-1:0] out_band
);
  logic [CHAN_W-1:0] chan_q;
  logic              ul_q;
  logic              vld_q;
  logic              take;
  range_e            rg;
  logic [IDX_W-1:0]  idx;

  assign in_ready = !vld_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      chan_q <= '0;
      ul_q   <= 1'b0;
    end else begin
      if (take) begin
        vld_q  <= 1'b1;
        chan_q <= in_chan;
        ul_q   <= in_uplink;
      end else if (out_ready) begin
        vld_q  <= 1'b0;
      end
    end
  end

  cfc_range_sel u_sel  (.chan(chan_q), .rg(rg), .idx(idx));
  cfc_freq_calc u_calc (.rg(rg), .idx(idx), .uplink(ul_q), .freq(out_freq));
  cfc_band_map  u_map  (.rg(rg), .band(out_band));

  assign out_valid = vld_q;
endmodule

// File: rtl/cfc_checker.sv
module cfc_checker
  import cfc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [FREQ_W-1:0] out_freq,
  input logic [BAND_W-1:0] out_band
);
  // R8
  accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_freq) && $stable(out_band));

  // R9
  stall_blocks_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R3
  band_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(out_band) == 1);

  // R7
  unmatched_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_freq == '1) |-> out_band == BAND_W'(8'h04));

  // R10
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

bind chan_freq_conv cfc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_freq(out_freq), .out_band(out_band)
);

// File: tb/sim_chan_freq_conv.sv
module sim_chan_freq_conv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_chan = '0;
  logic        in_uplink = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_freq;
  logic [7:0]  out_band;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  chan_freq_conv u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_chan(in_chan), .in_uplink(in_uplink), .out_valid(out_valid),
    .out_ready(out_ready), .out_freq(out_freq), .out_band(out_band)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One accepted word; result checked one edge later.
  task automatic conv(string req, logic [15:0] ch, logic ul,
                      logic [15:0] ef, logic [7:0] eb);
    @(negedge clk);
    in_chan = ch; in_uplink = ul; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, 32'(out_valid), 32'd1);
    chk({req, " freq"}, 32'(out_freq), 32'(ef));
    chk({req, " band"}, 32'(out_band), 32'(eb));
  endtask

  task automatic t_reset;
    chk("R10 out_valid", 32'(out_valid), 32'd0);
    chk("R10 in_ready", 32'(in_ready), 32'd1);
  endtask

  task automatic t_flag_mask;
    conv("R1 bits14..12 ul", 16'h700A, 1'b1, 16'd8920, 8'h02);
    conv("R1 bit12 dl", 16'h1080, 1'b0, 16'd8692, 8'h01);
  endtask

  task automatic t_pcs;
    conv("R2 pcs 512 ul", 16'h8200, 1'b1, 16'd18502, 8'h08);
    conv("R2 pcs 810 dl", 16'h832A, 1'b0, 16'd19898, 8'h08);
    conv("R2 pcs over index 0", 16'h8000, 1'b1, 16'd17478, 8'h08);
  endtask

  task automatic t_spans;
    conv("R3 R4 900 lo", 16'd0, 1'b1, 16'd8900, 8'h02);
    conv("R3 R4 900 hi", 16'd124, 1'b1, 16'd9148, 8'h02);
    conv("R3 R4 850 hi", 16'd251, 1'b1, 16'd8488, 8'h01);
    conv("R3 R4 1800 hi", 16'd885, 1'b1, 16'd17848, 8'h04);
    conv("R3 R4 450 hi", 16'd293, 1'b1, 16'd4574, 8'h10);
    conv("R3 R4 480 hi", 16'd340, 1'b1, 16'd4858, 8'h20);
    conv("R3 R4 810 hi", 16'd425, 1'b1, 16'd8210, 8'h80);
    conv("R3 R4 750 hi", 16'd511, 1'b1, 16'd7618, 8'h40);
  endtask

  task automatic t_ext900;
    conv("R5 ext lo", 16'd955, 1'b1, 16'd8762, 8'h02);
    conv("R5 ext hi", 16'd1023, 1'b1, 16'd8898, 8'h02);
  endtask

  task automatic t_downlink;
    conv("R6 900", 16'd0, 1'b0, 16'd9350, 8'h02);
    conv("R6 ext", 16'd955, 1'b0, 16'd9212, 8'h02);
    conv("R6 1800", 16'd512, 1'b0, 16'd18052, 8'h04);
    conv("R6 450", 16'd259, 1'b0, 16'd4606, 8'h10);
    conv("R6 480", 16'd306, 1'b0, 16'd4890, 8'h20);
    conv("R6 810", 16'd350, 1'b0, 16'd8510, 8'h80);
    conv("R6 750", 16'd438, 1'b0, 16'd7772, 8'h40);
  endtask

  task automatic t_unmatched;
    conv("R7 125 ul", 16'd125, 1'b1, 16'hFFFF, 8'h04);
    conv("R7 252 dl", 16'd252, 1'b0, 16'hFFFF, 8'h04);
    conv("R7 300 ul", 16'd300, 1'b1, 16'hFFFF, 8'h04);
    conv("R7 4095 dl", 16'h0FFF, 1'b0, 16'hFFFF, 8'h04);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    in_chan = 16'd0; in_uplink = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    chk("R8 first word valid", 32'(out_valid), 32'd1);
    chk("R9 in_ready low", 32'(in_ready), 32'd0);
    in_chan = 16'd512;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 held freq", 32'(out_freq), 32'd8900);
      chk("R9 held band", 32'(out_band), 32'h02);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 handover valid", 32'(out_valid), 32'd1);
    chk("R9 handover freq", 32'(out_freq), 32'd17102);
    @(negedge clk);
    chk("R8 drained", 32'(out_valid), 32'd0);
  endtask

  initial begin
    #1;
    t_reset;
    #10 rst_n = 1'b1;
    t_flag_mask;
    t_pcs;
    t_spans;
    t_ext900;
    t_downlink;
    t_unmatched;
    t_backpressure;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule